// File: doc/BRIEF.md
# Latched Fault Status Aggregator

This block gathers fault indications from two load-switch channels and from the global supply, interface and mode monitors into one 16-bit status word. Channel faults are merged by type across the channels. Supply and interface faults keep their own bits. Two summary bits are derived from the global group: one for any global flag and one for any supply undervoltage. An active-low fault pin reports any status bit that is not masked.

Fault bits are sticky by default. Once set, a bit stays set until a status read happens while its condition is no longer present. A configuration bit switches the supply and channel bits to follow their live condition instead. A power-on flag is set by reset and cleared by the first read. An interface watchdog expects a valid command within a selectable window and raises its own sticky flag when a window passes without one. The register bus decode sits outside the block. It drives the read strobe and the configuration bits.

Top module: `fault_status_agg`

## Requirements
- R1: After reset the status word is 0x0347 (bits 0, 1, 2, 6, 8, 9 set) and `fault_n` is low.
- R2: With `cfg_latch_dis`=0, a set fault bit stays set after its condition ends. A `stat_rd` cycle clears it only if the condition is absent in that same cycle. The value seen during the read cycle is the value before the clear.
- R3: With `cfg_latch_dis`=1, the channel bits (15, 13, 12, 11, 10) and the supply bits (2, 1, 0) take the live condition one cycle later and drop when it goes away.
- R4: Bit 6 (power-on) is set only by reset and clears after any `stat_rd`. A later read returns 0 there.
- R5: Bit 8 is the OR of bits 0 to 4, 6 and 7. Bit 9 is the OR of bits 0 to 2. Bit 7 follows `limp_home` one cycle late. Bits 5 and 14 read 0.
- R6: Bits 15 (I2T), 13 (thermal), 12 (current limit), 11 (short to supply) and 10 (open load, on or off state) each OR their fault type over both channels. `ch_fault[c]` is the registered OR of all fault inputs of channel c.
- R7: With `cfg_wd_en`=1, bit 3 sets L cycles after the edge that enabled the watchdog or sampled `cmd_valid`. L is TO0..TO3 for `cfg_wd_sel` 0..3. The watchdog never fires while disabled.
- R8: A `cmd_valid` sampled in the cycle the window would end suppresses the expiry and restarts the count.
- R9: Mask bits 0 (VBB undervoltage), 3 (on-state open load), 4 (off-state open load), 5 (short to supply) and 6 (current limit) only keep their source off `fault_n`. The status bit still sets.
- R10: Mask bits 1 (watchdog) and 2 (SPI error) stop their source from setting status bits 3 and 4, and keep those bits off `fault_n`.
- R11: `fault_n` is low exactly when some status source is set and not masked from the pin.
- R12: A one-cycle `spi_err` sets bit 4. Bit 4 and bit 3 stay latched even when `cfg_latch_dis`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flt_ilim | input | NCH | Per-channel current-limit turn-off |
| flt_tsd | input | NCH | Per-channel thermal shutdown |
| flt_short | input | NCH | Per-channel off-state short to supply |
| flt_ol_on | input | NCH | Per-channel on-state open load |
| flt_ol_off | input | NCH | Per-channel off-state open load |
| flt_i2t | input | NCH | Per-channel I2T trip |
| vbb_uv | input | 1 | Battery supply undervoltage level |
| vbb_uv_warn | input | 1 | Battery supply undervoltage warning level |
| vdd_uv | input | 1 | Logic supply undervoltage level |
| limp_home | input | 1 | Limp-home mode active level |
| spi_err | input | 1 | Interface error strobe |
| cmd_valid | input | 1 | Valid command strobe (watchdog kick) |
| stat_rd | input | 1 | Status word read strobe |
| cfg_mask | input | 7 | Mask bits, positions as in R9/R10 |
| cfg_latch_dis | input | 1 | 1: fault bits follow live condition |
| cfg_wd_en | input | 1 | Watchdog enable |
| cfg_wd_sel | input | 2 | Watchdog window select |
| status | output | 16 | Status word |
| ch_fault | output | NCH | Per-channel any-fault summary |
| fault_n | output | 1 | Active-low fault pin |

## Verification
A sticky bit that fails to hold or that clears during a read while its condition is still present shows up as a wrong status word in the cycle after that read. A stuck power-on flag keeps `fault_n` low forever. A watchdog counter off by one moves the appearance of bit 3 by one cycle from the expected L-cycle point, so samples are taken at L-1 and L. A mask wired to the wrong source reveals itself on `fault_n` in the same cycle the mask changes, because the pin logic is combinational from the flags.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

  localparam int NFLAG = 13;

  // internal flag indices
  localparam int F_VBB_UV  = 0;
  localparam int F_VBB_WRN = 1;
  localparam int F_VDD_UV  = 2;
  localparam int F_WD      = 3;
  localparam int F_SPI     = 4;
  localparam int F_POR     = 5;
  localparam int F_LIMP    = 6;
  localparam int F_OL_ON   = 7;
  localparam int F_OL_OFF  = 8;
  localparam int F_SHORT   = 9;
  localparam int F_ILIM    = 10;
  localparam int F_TSD     = 11;
  localparam int F_I2T     = 12;

  // flags set by reset: supply undervoltages and power-on
  localparam logic [NFLAG-1:0] FLAG_RST = 13'h0027;

  function automatic int unsigned wd_cycles(input logic [1:0] sel,
                                            input int unsigned t0, input int unsigned t1,
                                            input int unsigned t2, input int unsigned t3);
    case (sel)
      2'd0:    return t0;
      2'd1:    return t1;
      2'd2:    return t2;
      default: return t3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // expands the 7 configuration mask bits onto the flag vector
  function automatic logic [NFLAG-1:0] pin_mask(input logic [6:0] m);
    logic [NFLAG-1:0] r;
    r = '0;
    r[F_VBB_UV] = m[0];
    r[F_WD]     = m[1];
    r[F_SPI]    = m[2];
    r[F_OL_ON]  = m[3];
    r[F_OL_OFF] = m[4];
    r[F_SHORT]  = m[5];
    r[F_ILIM]   = m[6];
    return r;
  endfunction

  function automatic logic [15:0] pack_status(input logic [NFLAG-1:0] f);
    logic [15:0] s;
    s      = '0;
    s[0]   = f[F_VBB_UV];
    s[1]   = f[F_VBB_WRN];
    s[2]   = f[F_VDD_UV];
    s[3]   = f[F_WD];
    s[4]   = f[F_SPI];
    s[6]   = f[F_POR];
    s[7]   = f[F_LIMP];
    s[8]   = f[F_VBB_UV] | f[F_VBB_WRN] | f[F_VDD_UV] | f[F_WD] |
             f[F_SPI] | f[F_POR] | f[F_LIMP];
    s[9]   = f[F_VBB_UV] | f[F_VBB_WRN] | f[F_VDD_UV];
    s[10]  = f[F_OL_ON] | f[F_OL_OFF];
    s[11]  = f[F_SHORT];
    s[12]  = f[F_ILIM];
    s[13]  = f[F_TSD];
    s[15]  = f[F_I2T];
    return s;
  endfunction

endpackage

// File: rtl/fsa_sticky.sv
module fsa_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd,
  input  logic follow,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_VAL;
    else if (follow) q <= set;
    else             q <= set | (q & ~rd);
  end
endmodule

// File: rtl/fsa_watchdog.sv
module fsa_watchdog #(
  parameter int unsigned TO0 = 4000,
  parameter int unsigned TO1 = 4000000,
  parameter int unsigned TO2 = 8000000,
  parameter int unsigned TO3 = 12000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int unsigned TMAX = fsa_pkg::max4(TO0, TO1, TO2, TO3);
  localparam int CW = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          en_q;
  logic          restart;

  assign lim     = CW'(fsa_pkg::wd_cycles(sel, TO0, TO1, TO2, TO3) - 1);
  assign restart = ~en | ~en_q | kick;
  assign expire  = en & en_q & ~kick & (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= en;
      if (restart || expire) cnt <= '0;
      else                   cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/fsa_fault_pin.sv
module fsa_fault_pin #(
  parameter int NF = fsa_pkg::NFLAG
) (
  input  logic [NF-1:0] flags,
  input  logic [6:0]    mask,
  output logic          fault_n
);
  logic [NF-1:0] visible;
  assign visible = flags & ~fsa_pkg::pin_mask(mask);
  assign fault_n = ~(|visible);
endmodule

// File: rtl/fault_status_agg.sv
module fault_status_agg #(
  parameter int          NCH = 2,
  parameter int unsigned TO0 = 4000,
  parameter int unsigned TO1 = 4000000,
  parameter int unsigned TO2 = 8000000,
  parameter int unsigned TO3 = 12000000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] flt_ilim,
  input  logic [NCH-1:0] flt_tsd,
  input  logic [NCH-1:0] flt_short,
  input  logic [NCH-1:0] flt_ol_on,
  input  logic [NCH-1:0] flt_ol_off,
  input  logic [NCH-1:0] flt_i2t,
  input  logic           vbb_uv,
  input  logic           vbb_uv_warn,
  input  logic           vdd_uv,
  input  logic           limp_home,
  input  logic           spi_err,
  input  logic           cmd_valid,
  input  logic           stat_rd,
  input  logic [6:0]     cfg_mask,
  input  logic           cfg_latch_dis,
  input  logic           cfg_wd_en,
  input  logic [1:0]     cfg_wd_sel,
  output logic [15:0]    status,
  output logic [NCH-1:0] ch_fault,
  output logic           fault_n
);
  import fsa_pkg::*;

  logic              wd_expire;
  logic [NFLAG-1:0]  flag_set;
  logic [NFLAG-1:0]  flag_follow;
  logic [NFLAG-1:0]  flags;

  fsa_watchdog #(.TO0(TO0), .TO1(TO1), .TO2(TO2), .TO3(TO3)) wdog_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_wd_en),
    .kick   (cmd_valid),
    .sel    (cfg_wd_sel),
    .expire (wd_expire)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[F_VBB_UV]  = vbb_uv;
    flag_set[F_VBB_WRN] = vbb_uv_warn;
    flag_set[F_VDD_UV]  = vdd_uv;
    flag_set[F_WD]      = wd_expire & ~cfg_mask[1];
    flag_set[F_SPI]     = spi_err & ~cfg_mask[2];
    flag_set[F_POR]     = 1'b0;
    flag_set[F_LIMP]    = limp_home;
    flag_set[F_OL_ON]   = |flt_ol_on;
    flag_set[F_OL_OFF]  = |flt_ol_off;
    flag_set[F_SHORT]   = |flt_short;
    flag_set[F_ILIM]    = |flt_ilim;
    flag_set[F_TSD]     = |flt_tsd;
    flag_set[F_I2T]     = |flt_i2t;

    flag_follow         = {NFLAG{cfg_latch_dis}};
    flag_follow[F_WD]   = 1'b0;
    flag_follow[F_SPI]  = 1'b0;
    flag_follow[F_POR]  = 1'b0;
    flag_follow[F_LIMP] = 1'b1;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    fsa_sticky #(.RST_VAL(FLAG_RST[g])) bit_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (flag_set[g]),
      .rd     (stat_rd),
      .follow (flag_follow[g]),
      .q      (flags[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_fault[c] <= 1'b0;
      else        ch_fault[c] <= flt_ilim[c] | flt_tsd[c] | flt_short[c] |
                                 flt_ol_on[c] | flt_ol_off[c] | flt_i2t[c];
    end
  end

  assign status = pack_status(flags);

  fsa_fault_pin #(.NF(NFLAG)) pin_i (
    .flags   (flags),
    .mask    (cfg_mask),
    .fault_n (fault_n)
  );

endmodule

// File: rtl/fsa_checker.sv
module fsa_checker #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] flt_ilim,
  input logic [NCH-1:0] flt_tsd,
  input logic           stat_rd,
  input logic           cmd_valid,
  input logic [6:0]     cfg_mask,
  input logic           cfg_latch_dis,
  input logic           cfg_wd_en,
  input logic [15:0]    status,
  input logic           fault_n,
  input logic           wd_expire
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_latch_dis && status[12] && !stat_rd) |=> status[12]);

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|flt_ilim) |=> status[12]);

  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch_dis && !(|flt_tsd)) |=> !status[13]);

  p_por_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !status[6]);

  p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[9] |-> status[8]);

  p_wd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wd_en |-> !wd_expire);

  p_kick_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !wd_expire);

  p_spi_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mask[2] && !status[4]) |=> !status[4]);

  p_por_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> !fault_n);
endmodule

bind fault_status_agg fsa_checker #(.NCH(NCH)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .flt_ilim      (flt_ilim),
  .flt_tsd       (flt_tsd),
  .stat_rd       (stat_rd),
  .cmd_valid     (cmd_valid),
  .cfg_mask      (cfg_mask),
  .cfg_latch_dis (cfg_latch_dis),
  .cfg_wd_en     (cfg_wd_en),
  .status        (status),
  .fault_n       (fault_n),
  .wd_expire     (wd_expire)
);

// File: tb/fault_status_agg_tb_top.sv
module fault_status_agg_tb_top;
  localparam int CLK_P = 10;
  localparam int L0 = 16, L1 = 24, L2 = 32, L3 = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] flt_ilim = '0, flt_tsd = '0, flt_short = '0;
  logic [1:0] flt_ol_on = '0, flt_ol_off = '0, flt_i2t = '0;
  logic vbb_uv = 0, vbb_uv_warn = 0, vdd_uv = 0, limp_home = 0;
  logic spi_err = 0, cmd_valid = 0, stat_rd = 0;
  logic [6:0] cfg_mask = '0;
  logic cfg_latch_dis = 0, cfg_wd_en = 0;
  logic [1:0] cfg_wd_sel = '0;
  logic [15:0] status;
  logic [1:0] ch_fault;
  logic fault_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fault_status_agg #(.NCH(2), .TO0(L0), .TO1(L1), .TO2(L2), .TO3(L3)) dut_i (
    .clk(clk), .rst_n(rst_n), .flt_ilim(flt_ilim), .flt_tsd(flt_tsd),
    .flt_short(flt_short), .flt_ol_on(flt_ol_on), .flt_ol_off(flt_ol_off),
    .flt_i2t(flt_i2t), .vbb_uv(vbb_uv), .vbb_uv_warn(vbb_uv_warn),
    .vdd_uv(vdd_uv), .limp_home(limp_home), .spi_err(spi_err),
    .cmd_valid(cmd_valid), .stat_rd(stat_rd), .cfg_mask(cfg_mask),
    .cfg_latch_dis(cfg_latch_dis), .cfg_wd_en(cfg_wd_en),
    .cfg_wd_sel(cfg_wd_sel), .status(status), .ch_fault(ch_fault),
    .fault_n(fault_n));

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  task automatic t_reset();
    ticks(3); rst_n = 1; #1;
    chk("R1 reset word", status, 16'h0347);
    chk("R1 pin after reset", {15'd0, fault_n}, 16'h0000);
  endtask

  task automatic t_por();
    stat_rd = 1; #1;
    chk("R2 value during read", status, 16'h0347);
    tick(); stat_rd = 0;
    chk("R4 first read clears", status, 16'h0000);
    chk("R11 pin released", {15'd0, fault_n}, 16'h0001);
    do_read();
    chk("R4 second read power-on 0", {15'd0, status[6]}, 16'h0000);
  endtask

  task automatic t_latch();
    flt_ilim = 2'b10; tick(); flt_ilim = 0;
    chk("R6 ch_fault ch1", {14'd0, ch_fault}, 16'h0002);
    chk("R6 ilim summary", status, 16'h1000);
    chk("R11 pin on ilim", {15'd0, fault_n}, 16'h0000);
    ticks(3);
    chk("R2 held after condition gone", status, 16'h1000);
    chk("R6 ch_fault live drop", {14'd0, ch_fault}, 16'h0000);
    flt_ilim = 2'b01; do_read();
    chk("R2 read with condition keeps", status, 16'h1000);
    flt_ilim = 0; tick();
    chk("R2 still held", status, 16'h1000);
    do_read();
    chk("R2 read clears", status, 16'h0000);
    flt_short = 2'b01; flt_i2t = 2'b10; flt_ol_off = 2'b10; tick();
    flt_short = 0; flt_i2t = 0; flt_ol_off = 0;
    chk("R6 short/i2t/open-load bits", status, 16'h8C00);
    do_read();
    chk("R6 cleared", status, 16'h0000);
  endtask

  task automatic t_follow();
    cfg_latch_dis = 1; flt_tsd = 2'b01; tick();
    chk("R3 thermal follows", status, 16'h2000);
    tick();
    chk("R3 thermal stays while present", status, 16'h2000);
    flt_tsd = 0; tick();
    chk("R3 thermal drops", status, 16'h0000);
    vdd_uv = 1; tick();
    chk("R3 vdd follows", status, 16'h0304);
    vdd_uv = 0; tick();
    chk("R3 vdd drops", status, 16'h0000);
    cfg_latch_dis = 0;
  endtask

  task automatic t_summary();
    vbb_uv_warn = 1; tick(); vbb_uv_warn = 0; tick();
    chk("R5 warn with summaries latched", status, 16'h0302);
    do_read();
    chk("R5 cleared", status, 16'h0000);
    limp_home = 1; tick();
    chk("R5 limp-home sets bit7 and bit8", status, 16'h0180);
    limp_home = 0; tick();
    chk("R5 limp-home follows", status, 16'h0000);
  endtask

  task automatic t_mask();
    cfg_mask = 7'b1000000; flt_ilim = 2'b01; tick(); flt_ilim = 0;
    chk("R9 masked ilim status", status, 16'h1000);
    chk("R9 masked ilim pin", {15'd0, fault_n}, 16'h0001);
    cfg_mask = 0; #1;
    chk("R11 unmask asserts pin", {15'd0, fault_n}, 16'h0000);
    do_read();
    cfg_mask = 7'b0001000; flt_ol_on = 2'b10; tick(); flt_ol_on = 0;
    chk("R9 masked on-state open load status", status, 16'h0400);
    chk("R9 masked on-state open load pin", {15'd0, fault_n}, 16'h0001);
    flt_ol_off = 2'b01; tick(); flt_ol_off = 0;
    chk("R9 off-state open load unmasked pin", {15'd0, fault_n}, 16'h0000);
    do_read();
    cfg_mask = 7'b0000001; vbb_uv = 1; tick();
    chk("R9 masked vbb uv status", status, 16'h0301);
    chk("R9 masked vbb uv pin", {15'd0, fault_n}, 16'h0001);
    vbb_uv = 0; do_read();
    chk("R9 vbb uv cleared", status, 16'h0000);
    cfg_mask = 0;
  endtask

  task automatic t_spi();
    cfg_mask = 7'b0000100; spi_err = 1; tick(); spi_err = 0;
    chk("R10 masked spi no status", status, 16'h0000);
    chk("R10 masked spi no pin", {15'd0, fault_n}, 16'h0001);
    cfg_mask = 0; spi_err = 1; tick(); spi_err = 0;
    chk("R12 spi bit set", status, 16'h0110);
    cfg_latch_dis = 1; ticks(2);
    chk("R12 spi latched with latch-disable", status, 16'h0110);
    cfg_latch_dis = 0; do_read();
    chk("R12 spi cleared on read", status, 16'h0000);
  endtask

  task automatic t_wdog();
    ticks(50);
    chk("R7 disabled never fires", status, 16'h0000);
    cfg_wd_sel = 2'd0; cfg_wd_en = 1; tick();
    ticks(L0 - 1);
    chk("R7 sel0 before window end", {15'd0, status[3]}, 16'h0000);
    tick();
    chk("R7 sel0 at window end", status, 16'h0108);
    chk("R11 pin on watchdog", {15'd0, fault_n}, 16'h0000);
    do_read();
    chk("R7 cleared by read", status, 16'h0000);
    cmd_valid = 1; tick(); cmd_valid = 0;
    ticks(L0 - 1);
    cmd_valid = 1; tick(); cmd_valid = 0;
    chk("R8 kick in final cycle wins", {15'd0, status[3]}, 16'h0000);
    ticks(L0 - 1);
    chk("R8 restarted count not yet", {15'd0, status[3]}, 16'h0000);
    tick();
    chk("R8 restarted count fires", {15'd0, status[3]}, 16'h0001);
    do_read();
    cfg_wd_sel = 2'd3; cmd_valid = 1; tick(); cmd_valid = 0;
    ticks(L3 - 1);
    chk("R7 sel3 before window end", {15'd0, status[3]}, 16'h0000);
    tick();
    chk("R7 sel3 at window end", {15'd0, status[3]}, 16'h0001);
    do_read();
    cfg_mask = 7'b0000010; cmd_valid = 1; tick(); cmd_valid = 0;
    ticks(L3 + 2);
    chk("R10 masked watchdog status", status, 16'h0000);
    chk("R10 masked watchdog pin", {15'd0, fault_n}, 16'h0001);
    cfg_wd_en = 0; cfg_mask = 0;
    ticks(100);
    chk("R7 disabled again no flag", status, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_por();
    t_latch();
    t_follow();
    t_summary();
    t_mask();
    t_spi();
    t_wdog();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule